// File: doc/BRIEF.md
# Oversampled Smart-Card Character Receiver

This block receives half-duplex asynchronous smart-card characters on one serial line. It runs from a sample enable that pulses five times per elementary time unit (etu). The line first passes a two-flop synchronizer. The receiver waits in idle for a low level, which is the start bit. It then takes one sample of every following bit at a fixed tick offset near the bit centre. Ten slots are captured. The first eight are the data byte, least significant bit first. The ninth is the parity bit, and the tenth is kept but not used. One etu later the stop level is checked.

A character with a high stop level goes into a one-entry holding register, which is drained over a valid/ready handshake. The parity result for even parity travels with the byte. A low stop level means a framing error or a break. It sets a sticky error flag and no data is pushed. The receiver then waits for the line to return high before it looks for a new start. After a good stop the receiver re-arms at once, which tolerates a transmitter whose clock runs slightly fast.

Top module: `sc_char_rx`

## Requirements
- R1: After synchronous active-high reset, out_valid, frame_err and overrun are all 0, and the receiver is idle with the holding register empty.
- R2: The receiver leaves idle only on a tick where the synchronized line is low. It samples the first bit on the 8th tick after that detection tick and each later bit 5 ticks after the one before. Bits are shifted in least significant first, so the first bit after the start bit appears on out_data[0].
- R3: out_parity_err is the XOR of the eight data bits and the ninth captured bit, so it is 0 for a character with even parity.
- R4: When the line is high at the stop check, 5 ticks after the tenth sample, the character is delivered. The receiver re-arms at once, so characters sent back to back with a 12-etu period are all received.
- R5: When the line is low at the stop check, frame_err is set and holds until cleared. No character is delivered. No new start is looked for until the line has been seen high on a tick.
- R6: A one-cycle pulse on clr_err clears frame_err and overrun, except that a new error event in the same cycle sets its flag.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_parity_err stay unchanged.
- R8: If a character completes while the holding register is full and is not being read in that cycle, overrun is set. The new character is dropped and the held character is unchanged.
- R9: The level in the tenth slot has no effect. A character whose tenth slot is low and whose stop level is high is delivered without a framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sample enable, five pulses per etu |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| clr_err | input | 1 | One-cycle clear of the sticky flags |
| out_valid | output | 1 | Holding register holds a character |
| out_ready | input | 1 | Consumer takes the character |
| out_data | output | 8 | Received data byte |
| out_parity_err | output | 1 | Parity mismatch of the held character |
| frame_err | output | 1 | Sticky framing/break error |
| overrun | output | 1 | Sticky overrun, a character was dropped |

## Verification
The embedded properties check the following on every cycle:
- a character is delivered only after a tick, and never in the same cycle as a framing event;
- a start is taken only from a low line in idle;
- the held output is stable under backpressure;
- a completion into a full, unread register raises overrun without changing the held byte;
- the sticky flags keep their value until cleared.

Only the bench's scenarios can show the following:
- the bit ordering and the sample offsets, through correct bytes at the chosen bit timing;
- the parity result for each pattern;
- back-to-back reception that depends on immediate re-arming;
- the wait on a held-low break line;
- the tenth slot being ignored.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_BREAK = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
    import sc_rx_pkg::*;
#(
    parameter int TICKS_PER_ETU = 5,
    parameter int FIRST_DELAY   = 8,
    parameter int SLOTS         = 10,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              line_i,
    output logic              done_o,
    output logic              ferr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o
);
    localparam int MAXCNT = (FIRST_DELAY > TICKS_PER_ETU) ? FIRST_DELAY : TICKS_PER_ETU;
    localparam int CNT_W  = $clog2(MAXCNT);
    localparam int IDX_W  = $clog2(SLOTS + 1);

    typedef struct packed {
        rx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [SLOTS-1:0] shreg;
        logic             done;
        logic             ferr;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        fr_d.ferr = 1'b0;
        if (tick_en) begin
            case (fr_q.state)
                ST_IDLE: begin
                    if (!line_i) begin
                        fr_d.state = ST_SHIFT;
                        fr_d.cnt   = CNT_W'(FIRST_DELAY - 1);
                        fr_d.idx   = '0;
                    end
                end
                ST_SHIFT: begin
                    if (fr_q.cnt != '0) begin
                        fr_d.cnt = fr_q.cnt - 1'b1;
                    end else if (fr_q.idx != IDX_W'(SLOTS)) begin
                        fr_d.shreg = {line_i, fr_q.shreg[SLOTS-1:1]};
                        fr_d.idx   = fr_q.idx + 1'b1;
                        fr_d.cnt   = CNT_W'(TICKS_PER_ETU - 1);
                    end else if (line_i) begin
                        fr_d.done  = 1'b1;
                        fr_d.state = ST_IDLE;
                    end else begin
                        fr_d.ferr  = 1'b1;
                        fr_d.state = ST_BREAK;
                    end
                end
                ST_BREAK: begin
                    if (line_i) fr_d.state = ST_IDLE;
                end
                default: fr_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q.state <= ST_IDLE;
            fr_q.cnt   <= '0;
            fr_q.idx   <= '0;
            fr_q.shreg <= '0;
            fr_q.done  <= 1'b0;
            fr_q.ferr  <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done_o = fr_q.done;
    assign ferr_o = fr_q.ferr;
    assign data_o = fr_q.shreg[DATA_W-1:0];
    assign perr_o = ^fr_q.shreg[DATA_W:0];

    // R4: a completion only follows a tick
    p_done_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        fr_q.done |-> $past(tick_en));
    // R5: never deliver and flag framing together
    p_done_excl_ferr_r5: assert property (@(posedge clk) disable iff (rst)
        !(fr_q.done && fr_q.ferr));
    // R2: a start is taken from a low line in idle
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (fr_q.state == ST_IDLE && tick_en && !line_i) |=> (fr_q.state == ST_SHIFT));
    // R5: the break wait ends only on a high line
    p_break_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fr_q.state == ST_BREAK && !(tick_en && line_i)) |=> (fr_q.state == ST_BREAK));
endmodule

// File: rtl/sc_rx_out.sv
module sc_rx_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              clr_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_flag_o,
    output logic              ovr_flag_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  ovr_evt;

    always_comb begin
        hd_d    = hd_q;
        ovr_evt = 1'b0;
        if (hd_q.full && ready_i) hd_d.full = 1'b0;
        if (done_i) begin
            if (hd_q.full && !ready_i) begin
                ovr_evt = 1'b1;
            end else begin
                hd_d.full = 1'b1;
                hd_d.data = data_i;
                hd_d.perr = perr_i;
            end
        end
        if (ferr_i)       hd_d.ferr = 1'b1;
        else if (clr_i)   hd_d.ferr = 1'b0;
        if (ovr_evt)      hd_d.ovr  = 1'b1;
        else if (clr_i)   hd_d.ovr  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign valid_o     = hd_q.full;
    assign data_o      = hd_q.data;
    assign perr_o      = hd_q.perr;
    assign ferr_flag_o = hd_q.ferr;
    assign ovr_flag_o  = hd_q.ovr;

    // R7: held output stays put under backpressure
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (hd_q.full && !ready_i) |=> (hd_q.full && $stable(hd_q.data) && $stable(hd_q.perr)));
    // R8: a completion into a full unread register is dropped
    p_overrun_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (done_i && hd_q.full && !ready_i) |=> (hd_q.ovr && $stable(hd_q.data)));
    // R6: clear wins when no new framing event
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !ferr_i) |=> !hd_q.ferr);
    // R5: framing flag is sticky
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (hd_q.ferr && !clr_i) |=> hd_q.ferr);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
    parameter int TICKS_PER_ETU = 5,
    parameter int FIRST_DELAY   = 8,
    parameter int SLOTS         = 10,
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              rx_in,
    input  logic              clr_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_parity_err,
    output logic              frame_err,
    output logic              overrun
);
    logic              line_s;
    logic              done_w;
    logic              ferr_w;
    logic [DATA_W-1:0] data_w;
    logic              perr_w;

    sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_in),
        .dout(line_s)
    );

    sc_rx_frame #(
        .TICKS_PER_ETU(TICKS_PER_ETU),
        .FIRST_DELAY  (FIRST_DELAY),
        .SLOTS        (SLOTS),
        .DATA_W       (DATA_W)
    ) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .line_i (line_s),
        .done_o (done_w),
        .ferr_o (ferr_w),
        .data_o (data_w),
        .perr_o (perr_w)
    );

    sc_rx_out #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .done_i     (done_w),
        .data_i     (data_w),
        .perr_i     (perr_w),
        .ferr_i     (ferr_w),
        .clr_i      (clr_err),
        .ready_i    (out_ready),
        .valid_o    (out_valid),
        .data_o     (out_data),
        .perr_o     (out_parity_err),
        .ferr_flag_o(frame_err),
        .ovr_flag_o (overrun)
    );
endmodule

// File: tb/sc_char_rx_test.sv
`timescale 1ns/1ps
module sc_char_rx_test;
    localparam int CLK_PER_TICK = 4;
    localparam int CLK_PER_ETU  = 5 * CLK_PER_TICK;
    localparam int NVEC = 8;
    // [9] expected parity error, [8] parity bit sent, [7:0] data
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h01}, {1'b1, 1'b0, 8'h01},
        {1'b0, 1'b0, 8'hFF}, {1'b1, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b1, 8'h80}, {1'b0, 1'b0, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic rx_in = 1'b1;
    logic clr_err = 1'b0;
    logic out_ready = 1'b1;
    logic out_valid, out_parity_err, frame_err, overrun;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic [8:0] log_q [64];
    int log_n = 0;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    sc_char_rx uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rx_in(rx_in),
        .clr_err(clr_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_parity_err(out_parity_err),
        .frame_err(frame_err), .overrun(overrun)
    );

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == CLK_PER_TICK - 1) ? 0 : tick_cnt + 1;
        tick_en  <= (tick_cnt == CLK_PER_TICK - 1);
        if (!rst && out_valid && out_ready && log_n < 64) begin
            log_q[log_n] = {out_parity_err, out_data};
            log_n = log_n + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic p, input logic g1, input logic g2);
        rx_in = 1'b0;
        repeat (CLK_PER_ETU) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            repeat (CLK_PER_ETU) @(negedge clk);
        end
        rx_in = p;  repeat (CLK_PER_ETU) @(negedge clk);
        rx_in = g1; repeat (CLK_PER_ETU) @(negedge clk);
        rx_in = g2; repeat (CLK_PER_ETU) @(negedge clk);
        rx_in = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);

        // R2 R3 R4: table of characters sent back to back
        base = log_n;
        for (int v = 0; v < NVEC; v++) send_char(VEC[v][7:0], VEC[v][8], 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(log_n - base == NVEC, "R4 back-to-back count", log_n - base, NVEC);
        for (int v = 0; v < NVEC; v++) begin
            chk(log_q[base+v][7:0] == VEC[v][7:0], "R2 data", log_q[base+v][7:0], VEC[v][7:0]);
            chk(log_q[base+v][8] == VEC[v][9], "R3 parity_err", log_q[base+v][8], VEC[v][9]);
        end
        chk(frame_err == 1'b0, "R4 no frame_err", frame_err, 0);

        // R9 tenth slot low, stop high
        base = log_n;
        send_char(8'h5A, 1'b0, 1'b0, 1'b1);
        repeat (40) @(negedge clk);
        chk(log_n - base == 1, "R9 delivered", log_n - base, 1);
        chk(log_q[base][7:0] == 8'h5A, "R9 data", log_q[base][7:0], 8'h5A);
        chk(frame_err == 1'b0, "R9 no frame_err", frame_err, 0);

        // R5 break: line held low through the stop check and beyond
        base = log_n;
        send_char(8'h00, 1'b0, 1'b0, 1'b0);
        rx_in = 1'b0;
        repeat (3 * CLK_PER_ETU) @(negedge clk);
        chk(frame_err == 1'b1, "R5 frame_err set", frame_err, 1);
        chk(log_n == base, "R5 no delivery", log_n - base, 0);
        rx_in = 1'b1;
        repeat (2 * CLK_PER_ETU) @(negedge clk);
        chk(frame_err == 1'b1, "R5 sticky", frame_err, 1);
        chk(log_n == base, "R5 no delivery after idle", log_n - base, 0);
        send_char(8'h33, 1'b0, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(log_n - base == 1 && log_q[base][7:0] == 8'h33, "R5 re-armed", log_q[base][7:0], 8'h33);
        chk(frame_err == 1'b1, "R5 still sticky", frame_err, 1);

        // R6 clear
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
        chk(frame_err == 1'b0, "R6 cleared", frame_err, 0);

        // R7 R8 backpressure and overrun
        out_ready = 1'b0;
        base = log_n;
        send_char(8'h11, 1'b0, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'h11, "R7 held", out_data, 8'h11);
        send_char(8'h22, 1'b0, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(overrun == 1'b1, "R8 overrun", overrun, 1);
        chk(out_valid == 1'b1 && out_data == 8'h11, "R8 held unchanged", out_data, 8'h11);
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        chk(log_n - base == 1 && log_q[base][7:0] == 8'h11, "R8 dropped second", log_n - base, 1);
        chk(out_valid == 1'b0, "R7 drained", out_valid, 0);
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
        chk(overrun == 1'b0, "R6 overrun cleared", overrun, 0);

        // R1 reset in the middle of a character
        rx_in = 1'b0;
        repeat (3 * CLK_PER_ETU) @(negedge clk);
        rst = 1'b1; rx_in = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (CLK_PER_ETU * 12) @(negedge clk);
        chk(out_valid == 1'b0 && frame_err == 1'b0, "R1 mid-char reset", {out_valid, frame_err}, 0);
        base = log_n;
        send_char(8'hC3, 1'b0, 1'b1, 1'b1);
        repeat (40) @(negedge clk);
        chk(log_n - base == 1 && log_q[base][7:0] == 8'hC3, "R2 after reset", log_q[base][7:0], 8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule